// File: doc/BRIEF.md
# Prioritized Pin-Function Port Multiplexer

This block is an eight-pin general-purpose I/O port that can hand each of its pins to one of three owners: a PWM output channel, a signal of one of two SPI units, or the port's own output latch. Ownership is decided per pin by a fixed priority. An enabled PWM channel always wins. An enabled SPI unit wins next. Plain GPIO, steered by a data latch and a direction latch, takes the pin only when neither alternate function is enabled. The PWM and SPI engines sit outside the block and appear only as enable, mode and signal inputs.

Software reaches the port through a small register bus with two byte registers: the data latch and the direction latch. Reading the data register merges, bit by bit, the latch value for pins set as outputs with the synchronized pin level for pins set as inputs. The pin input passes through a two-stage synchronizer before it reaches the read path. The raw pin level is also returned to the SPI engines.

Top module: `pmux_port`

## Requirements
- R1: After reset the data latch and the direction latch both read 0x00, and with no alternate function enabled every pin has output enable 0.
- R2: While pwm_en[n] is 1, pin n has pin_oe 1 and pin_out equal to pwm_out[n], whatever the SPI enables, SPI mode and direction latch hold.
- R3: While pwm_en[n] is 0 and the SPI unit wired to pin n is enabled in master mode (spi_master bit 1), the SCK, SS and MOSI pins drive the engine's matching output with pin_oe 1. The MISO pin has pin_oe 0 and pin_out 0.
- R4: While pwm_en[n] is 0 and that SPI unit is enabled in slave mode (spi_master bit 0), only the MISO pin drives, carrying spi_miso_o. The SCK, SS and MOSI pins have pin_oe 0 and pin_out 0.
- R5: Pin wiring, from pin 7 down: unit 1 SCK, unit 1 SS, unit 1 MOSI, unit 1 MISO, unit 0 SS, unit 0 SCK, unit 0 MOSI, unit 0 MISO.
- R6: With neither alternate function owning pin n, pin_oe[n] equals direction bit n and pin_out[n] equals data bit n.
- R7: A read of the data register (address 0x0258) returns data bit n where direction bit n is 1. Where the direction bit is 0, it returns pin_in[n] as sampled two rising clock edges earlier.
- R8: A write with bus_we 1 at 0x0258 loads the data latch, and one at 0x0259 loads the direction latch, on the next rising edge. Writes to any other address change neither latch. Reads of any other address return 0x00, and reads of 0x0259 return the direction latch.
- R9: Each SPI unit's input signals (spi_sck_i, spi_ss_i, spi_mosi_i, spi_miso_i) follow the raw pin_in bit of the pin wired to them by R5, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register write strobe |
| bus_rdata | output | 8 | Register bus read data for bus_addr |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_out | input | 8 | Per-pin PWM channel waveform |
| spi_en | input | 2 | Enable of each SPI unit |
| spi_master | input | 2 | 1 = master, 0 = slave, per SPI unit |
| spi_sck_o | input | 2 | SCK driven by each SPI engine |
| spi_ss_o | input | 2 | SS driven by each SPI engine |
| spi_mosi_o | input | 2 | MOSI driven by each SPI engine |
| spi_miso_o | input | 2 | MISO driven by each SPI engine |
| spi_sck_i | output | 2 | SCK pin level returned to each SPI engine |
| spi_ss_i | output | 2 | SS pin level returned to each SPI engine |
| spi_mosi_i | output | 2 | MOSI pin level returned to each SPI engine |
| spi_miso_i | output | 2 | MISO pin level returned to each SPI engine |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The assertions assume that pin_in and the bus inputs move only between clock edges, so that the synchronizer's two-edge delay can be stated exactly. They also assume that enables and SPI signals are steady whenever an owner check is sampled. The bench meets both assumptions by changing every input on the falling edge and sampling one nanosecond later. The pin-read check is held off for the first two cycles after reset, until the synchronizer holds real samples. Enable combinations are applied as static settings rather than toggled at the edge.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

    localparam int SIGS_PER_UNIT = 4;

    typedef enum logic [1:0] {
        SIG_MISO = 2'd0,
        SIG_MOSI = 2'd1,
        SIG_SCK  = 2'd2,
        SIG_SS   = 2'd3
    } spi_sig_e;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_SPI  = 2'd1,
        OWN_PWM  = 2'd2
    } owner_e;

    // SPI unit wired to a pin: four consecutive pins per unit
    function automatic int unit_of_pin(input int idx);
        return idx / SIGS_PER_UNIT;
    endfunction

    // Signal wired to a pin; odd units swap SCK and SS in the upper slots
    function automatic spi_sig_e sig_of_pin(input int idx);
        int slot;
        bit odd;
        slot = idx % SIGS_PER_UNIT;
        odd  = ((idx / SIGS_PER_UNIT) % 2) == 1;
        case (slot)
            0:       return SIG_MISO;
            1:       return SIG_MOSI;
            2:       return odd ? SIG_SS : SIG_SCK;
            default: return odd ? SIG_SCK : SIG_SS;
        endcase
    endfunction

endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_o == $past(d_i, 2));

endmodule

// File: rtl/pmux_regs.sv
module pmux_regs #(
    parameter int              W      = 8,
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0258
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic              we_i,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      dir_o,
    output logic              hit_data_o,
    output logic              hit_dir_o
);

    localparam logic [ADDR_W-1:0] DATA_OFS = BASE;
    localparam logic [ADDR_W-1:0] DIR_OFS  = BASE + ADDR_W'(1);

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        hit_data_o = (addr_i == DATA_OFS);
        hit_dir_o  = (addr_i == DIR_OFS);
        st_d = st_q;
        if (we_i && hit_data_o) st_d.data = wdata_i;
        if (we_i && hit_dir_o)  st_d.dir  = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign dir_o  = st_q.dir;

    // R8
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == BASE) |=> data_o == $past(wdata_i));

    // R8
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == BASE + ADDR_W'(1)) |=> dir_o == $past(wdata_i));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != BASE && addr_i != BASE + ADDR_W'(1)) |=>
            ($stable(data_o) && $stable(dir_o)));

endmodule

// File: rtl/pmux_pin_arb.sv
module pmux_pin_arb
    import pmux_pkg::*;
#(
    parameter spi_sig_e SIG = SIG_MISO
) (
    input  logic   pwm_en_i,
    input  logic   pwm_val_i,
    input  logic   spi_en_i,
    input  logic   spi_master_i,
    input  logic   spi_sck_i,
    input  logic   spi_ss_i,
    input  logic   spi_mosi_i,
    input  logic   spi_miso_i,
    input  logic   gpio_dir_i,
    input  logic   gpio_data_i,
    output logic   oe_o,
    output logic   out_o,
    output owner_e owner_o
);

    logic spi_drives;
    logic spi_val;

    // Direction of this SPI signal: MISO is driven by a slave, the rest by a master
    generate
        if (SIG == SIG_MISO) begin : g_miso
            assign spi_drives = !spi_master_i;
            assign spi_val    = spi_miso_i;
        end else if (SIG == SIG_MOSI) begin : g_mosi
            assign spi_drives = spi_master_i;
            assign spi_val    = spi_mosi_i;
        end else if (SIG == SIG_SCK) begin : g_sck
            assign spi_drives = spi_master_i;
            assign spi_val    = spi_sck_i;
        end else begin : g_ss
            assign spi_drives = spi_master_i;
            assign spi_val    = spi_ss_i;
        end
    endgenerate

    always_comb begin
        if (pwm_en_i) begin
            owner_o = OWN_PWM;
            oe_o    = 1'b1;
            out_o   = pwm_val_i;
        end else if (spi_en_i) begin
            owner_o = OWN_SPI;
            oe_o    = spi_drives;
            out_o   = spi_drives & spi_val;
        end else begin
            owner_o = OWN_GPIO;
            oe_o    = gpio_dir_i;
            out_o   = gpio_data_i;
        end
    end

endmodule

// File: rtl/pmux_port.sv
module pmux_port
    import pmux_pkg::*;
#(
    parameter int              SPI_UNITS = 2,
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0258
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_we,
    output logic [7:0]           bus_rdata,
    input  logic [7:0]           pwm_en,
    input  logic [7:0]           pwm_out,
    input  logic [SPI_UNITS-1:0] spi_en,
    input  logic [SPI_UNITS-1:0] spi_master,
    input  logic [SPI_UNITS-1:0] spi_sck_o,
    input  logic [SPI_UNITS-1:0] spi_ss_o,
    input  logic [SPI_UNITS-1:0] spi_mosi_o,
    input  logic [SPI_UNITS-1:0] spi_miso_o,
    output logic [SPI_UNITS-1:0] spi_sck_i,
    output logic [SPI_UNITS-1:0] spi_ss_i,
    output logic [SPI_UNITS-1:0] spi_mosi_i,
    output logic [SPI_UNITS-1:0] spi_miso_i,
    input  logic [7:0]           pin_in,
    output logic [7:0]           pin_out,
    output logic [7:0]           pin_oe
);

    localparam int PINS = SPI_UNITS * SIGS_PER_UNIT;

    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pin_sync;
    logic            hit_data;
    logic            hit_dir;
    owner_e          owner [PINS];

    pmux_regs #(.W(PINS), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .we_i       (bus_we),
        .data_o     (data_q),
        .dir_o      (dir_q),
        .hit_data_o (hit_data),
        .hit_dir_o  (hit_dir)
    );

    pmux_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pin_sync)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            localparam int       U = unit_of_pin(i);
            localparam spi_sig_e S = sig_of_pin(i);

            pmux_pin_arb #(.SIG(S)) u_arb (
                .pwm_en_i     (pwm_en[i]),
                .pwm_val_i    (pwm_out[i]),
                .spi_en_i     (spi_en[U]),
                .spi_master_i (spi_master[U]),
                .spi_sck_i    (spi_sck_o[U]),
                .spi_ss_i     (spi_ss_o[U]),
                .spi_mosi_i   (spi_mosi_o[U]),
                .spi_miso_i   (spi_miso_o[U]),
                .gpio_dir_i   (dir_q[i]),
                .gpio_data_i  (data_q[i]),
                .oe_o         (pin_oe[i]),
                .out_o        (pin_out[i]),
                .owner_o      (owner[i])
            );

            // Return path to the SPI engine, one pin per unit signal
            if (S == SIG_MISO) begin : g_ret_miso
                assign spi_miso_i[U] = pin_in[i];
            end else if (S == SIG_MOSI) begin : g_ret_mosi
                assign spi_mosi_i[U] = pin_in[i];
            end else if (S == SIG_SCK) begin : g_ret_sck
                assign spi_sck_i[U] = pin_in[i];
            end else begin : g_ret_ss
                assign spi_ss_i[U] = pin_in[i];
            end

            // R2
            pwm_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pwm_en[i] |-> (pin_oe[i] && pin_out[i] == pwm_out[i]
                               && owner[i] == OWN_PWM));

            // R6
            gpio_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!pwm_en[i] && !spi_en[U]) |->
                    (pin_oe[i] == dir_q[i] && pin_out[i] == data_q[i]));

            if (S == SIG_MISO) begin : g_chk_miso
                // R3
                master_miso_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pwm_en[i] && spi_en[U] && spi_master[U]) |->
                        (!pin_oe[i] && !pin_out[i]));
            end else begin : g_chk_other
                // R4
                slave_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pwm_en[i] && spi_en[U] && !spi_master[U]) |->
                        (!pin_oe[i] && !pin_out[i]));
            end
        end
    endgenerate

    // Read mux: latch for output pins, synchronized level for input pins
    always_comb begin
        bus_rdata = '0;
        if (hit_data)     bus_rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
        else if (hit_dir) bus_rdata = dir_q;
    end

    // Checker-only warm-up count so the pin-read check looks back only over sampled cycles
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R7
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && bus_addr == BASE && dir_q == '0) |->
            bus_rdata == $past(pin_in, 2));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (data_q == '0 && dir_q == '0));

endmodule

// File: tb/tb_pmux_port.sv
`timescale 1ns/1ps
module tb_pmux_port;

    localparam logic [15:0] A_DATA = 16'h0258;
    localparam logic [15:0] A_DIR  = 16'h0259;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pwm_en = '0, pwm_out = '0;
    logic [1:0]  spi_en = '0, spi_master = '0;
    logic [1:0]  spi_sck_o = '0, spi_ss_o = '0, spi_mosi_o = '0, spi_miso_o = '0;
    logic [1:0]  spi_sck_i, spi_ss_i, spi_mosi_i, spi_miso_i;
    logic [7:0]  pin_in = '0, pin_out, pin_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pmux_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_en(pwm_en), .pwm_out(pwm_out),
        .spi_en(spi_en), .spi_master(spi_master), .spi_sck_o(spi_sck_o),
        .spi_ss_o(spi_ss_o), .spi_mosi_o(spi_mosi_o), .spi_miso_o(spi_miso_o),
        .spi_sck_i(spi_sck_i), .spi_ss_i(spi_ss_i), .spi_mosi_i(spi_mosi_i),
        .spi_miso_i(spi_miso_i), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Wiring from R5: signal code 0 MISO, 1 MOSI, 2 SCK, 3 SS
    function automatic int sig_at(input int p);
        case (p)
            7: return 2; 6: return 3; 5: return 1; 4: return 0;
            3: return 3; 2: return 2; 1: return 1; default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        @(negedge clk);
        bus_read(A_DATA, r); check("R1 data after reset", r, 8'h00);
        bus_read(A_DIR, r);  check("R1 dir after reset", r, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);
    endtask

    task automatic t_gpio_regs;
        logic [7:0] r;
        bus_write(A_DIR, 8'hFF);
        bus_write(A_DATA, 8'h3C);
        bus_read(A_DATA, r); check("R7 latch readback", r, 8'h3C);
        bus_read(A_DIR, r);  check("R8 dir readback", r, 8'hFF);
        check("R6 gpio out", pin_out, 8'h3C);
        check("R6 gpio oe", pin_oe, 8'hFF);
        bus_write(16'h025A, 8'h00);
        bus_write(16'h0257, 8'h00);
        bus_read(A_DATA, r); check("R8 stray write data", r, 8'h3C);
        bus_read(A_DIR, r);  check("R8 stray write dir", r, 8'hFF);
        bus_read(16'h025A, r); check("R8 other address reads zero", r, 8'h00);
    endtask

    task automatic t_read_mix;
        logic [7:0] r;
        bus_write(A_DIR, 8'h0F);
        bus_write(A_DATA, 8'h5A);
        @(negedge clk); pin_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        bus_read(A_DATA, r); check("R7 mixed read", r, 8'hCA);
        @(negedge clk); pin_in = 8'h30;
        @(negedge clk);
        bus_read(A_DATA, r); check("R7 one edge still old", r, 8'hCA);
        @(negedge clk);
        bus_read(A_DATA, r); check("R7 two edges new", r, 8'h3A);
    endtask

    task automatic t_walk;
        logic exp_oe, exp_out, pe, se, ms, dr;
        int u, s;
        logic [1:0] v;
        pwm_out = 8'h96; spi_sck_o = 2'b10; spi_ss_o = 2'b01;
        spi_mosi_o = 2'b11; spi_miso_o = 2'b10;
        bus_write(A_DATA, 8'h69);
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 16; c++) begin
                pe = c[0]; se = c[1]; ms = c[2]; dr = c[3];
                bus_write(A_DIR, dr ? 8'hFF : 8'h00);
                @(negedge clk);
                pwm_en = pe ? (8'h01 << p) : 8'h00;
                spi_en = se ? 2'b11 : 2'b00;
                spi_master = ms ? 2'b11 : 2'b00;
                #1;
                u = p / 4; s = sig_at(p);
                if (pe) begin
                    exp_oe = 1'b1; exp_out = pwm_out[p];
                    check("R2 pwm owner", {pin_oe[p], pin_out[p]}, {exp_oe, exp_out});
                end else if (se) begin
                    v = (s == 0) ? spi_miso_o : (s == 1) ? spi_mosi_o :
                        (s == 2) ? spi_sck_o : spi_ss_o;
                    exp_oe  = (s == 0) ? !ms : ms;
                    exp_out = exp_oe & v[u];
                    if (ms) check("R3 spi master owner", {pin_oe[p], pin_out[p]}, {exp_oe, exp_out});
                    else    check("R4 spi slave owner", {pin_oe[p], pin_out[p]}, {exp_oe, exp_out});
                end else begin
                    exp_oe = dr; exp_out = 1'b1 ^ (p == 1 || p == 2 || p == 4 || p == 7);
                    exp_out = (8'h69 >> p) & 1'b1;
                    check("R6 gpio owner", {pin_oe[p], pin_out[p]}, {exp_oe, exp_out});
                end
            end
        end
        pwm_en = '0; spi_en = '0;
    endtask

    task automatic t_map;
        @(negedge clk);
        spi_en = 2'b11; spi_master = 2'b11; pwm_en = '0;
        spi_sck_o = 2'b10; spi_ss_o = 2'b00; spi_mosi_o = 2'b00; spi_miso_o = 2'b00; #1;
        check("R5 unit1 SCK on pin7", pin_out, 8'h80);
        spi_sck_o = 2'b00; spi_ss_o = 2'b10; #1;
        check("R5 unit1 SS on pin6", pin_out, 8'h40);
        spi_ss_o = 2'b00; spi_mosi_o = 2'b10; #1;
        check("R5 unit1 MOSI on pin5", pin_out, 8'h20);
        spi_mosi_o = 2'b00; spi_ss_o = 2'b01; #1;
        check("R5 unit0 SS on pin3", pin_out, 8'h08);
        spi_ss_o = 2'b00; spi_sck_o = 2'b01; #1;
        check("R5 unit0 SCK on pin2", pin_out, 8'h04);
        spi_sck_o = 2'b00; spi_mosi_o = 2'b01; #1;
        check("R5 unit0 MOSI on pin1", pin_out, 8'h02);
        spi_mosi_o = 2'b00; spi_master = 2'b00; spi_miso_o = 2'b10; #1;
        check("R5 unit1 MISO on pin4", pin_out, 8'h10);
        spi_miso_o = 2'b01; #1;
        check("R5 unit0 MISO on pin0", pin_out, 8'h01);
        check("R4 slave oe pattern", pin_oe, 8'h11);
        spi_master = 2'b11; #1;
        check("R3 master oe pattern", pin_oe, 8'hEE);
        spi_en = '0; spi_miso_o = '0;
    endtask

    task automatic t_spi_return;
        logic [1:0] exp;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            pin_in = 8'h01 << p;
            #1;
            exp = 2'b01 << (p / 4);
            case (sig_at(p))
                0: check("R9 MISO return", spi_miso_i, exp);
                1: check("R9 MOSI return", spi_mosi_i, exp);
                2: check("R9 SCK return", spi_sck_i, exp);
                default: check("R9 SS return", spi_ss_i, exp);
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_gpio_regs;
        t_read_mix;
        t_walk;
        t_map;
        t_spi_return;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule